// File: doc/BRIEF.md
# Configuration Restart Word Sequencer

This block lets user logic ask the device to wipe its configuration and load a new image from external flash. When a trigger arrives it streams a fixed, ordered packet of configuration words into the on-chip configuration access port. The packet is built as follows. It opens with a bus-width dummy word and the synchronisation word. It then writes the primary and fallback image start addresses and several setup registers. Next comes the reboot command. It closes with no-op padding words so that the command is flushed through the port.

The port takes 16 bits per clock. Each 32-bit word therefore goes out as two halves, upper half first, while an active-low select and an active-low write strobe are held low. The primary address, the fallback address, the flash read opcode and the number of padding words are parameters. The address-carrying words are assembled from these parameters. With the default values the stream matches the standard restart header exactly.

Top module: `cfg_restart_seq`

## Requirements
- R1: The burst begins with the dummy word 0xFFFFFFFF and then the sync word 0xAA995566. Each word goes out as its bits [31:16] in one cycle and its bits [15:0] in the next.
- R2: Words 2 to 10 of the burst (counting from 0) are 0x31E1FFFF, {0x3261, PRIMARY_ADDR[15:0]}, {0x3281, READ_OP, PRIMARY_ADDR[23:16]}, {0x32A1, GOLDEN_ADDR[15:0]}, {0x32C1, READ_OP, GOLDEN_ADDR[23:16]}, 0x32E10000, 0x30A10000, 0x33012100 and 0x3201001F, in that order. With the defaults (0x400000, 0x010000, opcode 0x03), words 3 to 6 are 0x32610000, 0x32810340, 0x32A10000 and 0x32C10301.
- R3: Word 11 is the reboot command 0x30A1000E. It is followed by PAD_WORDS no-op words of 0x20002000.
- R4: Select and write go low together in the cycle after an accepted trigger. They stay low for exactly 2*(12+PAD_WORDS) cycles and go high in the cycle after the last half-word.
- R5: After reset, and whenever idle, select and write are high, busy is low and the data bus is 0xFFFF.
- R6: A rising edge on the trigger input while idle starts a burst. A trigger held high starts only one burst.
- R7: Trigger edges that arrive during a burst are ignored. The burst content and length stay the same, and no second burst follows.
- R8: Busy is high in exactly the cycles in which select is low.
- R9: A trigger edge in the first idle cycle after a burst is accepted, and a new burst starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Restart request; its rising edge is captured |
| busy_o | output | 1 | High while a burst is being emitted |
| cap_sel_no | output | 1 | Configuration port select, active low |
| cap_wr_no | output | 1 | Configuration port write strobe, active low |
| cap_data_o | output | 16 | Configuration port data, one half-word per cycle |

## Verification
The sequencer's internal state is a burst flag and a half-word counter. A skipped or repeated count appears on the data bus as a wrong half-word in the very cycle it happens. An off-by-one end condition changes the number of select-low cycles, and this is seen one cycle after the last expected half. A trigger that is wrongly captured or latched shows up as an extra burst within a cycle or two of the end of the first one. For this reason the bench compares every half-word in order and then watches the bus idle after each burst. A second instance with different addresses, opcode and padding count exposes any word that is fixed where it should be built from the parameters.

// File: rtl/cfg_restart_pkg.sv
package cfg_restart_pkg;

    localparam int HALF_W    = 16;
    localparam int WORD_W    = 2 * HALF_W;
    localparam int HDR_WORDS = 12;   // dummy, sync, nine register writes, reboot

    localparam logic [WORD_W-1:0] W_DUMMY   = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] W_SYNC    = 32'hAA99_5566;
    localparam logic [WORD_W-1:0] W_TIMER   = 32'h31E1_FFFF;
    localparam logic [HALF_W-1:0] H_PRI_LO  = 16'h3261;
    localparam logic [HALF_W-1:0] H_PRI_HI  = 16'h3281;
    localparam logic [HALF_W-1:0] H_GLD_LO  = 16'h32A1;
    localparam logic [HALF_W-1:0] H_GLD_HI  = 16'h32C1;
    localparam logic [WORD_W-1:0] W_USER    = 32'h32E1_0000;
    localparam logic [WORD_W-1:0] W_CMD_NUL = 32'h30A1_0000;
    localparam logic [WORD_W-1:0] W_CTL     = 32'h3301_2100;
    localparam logic [WORD_W-1:0] W_HC_OPT  = 32'h3201_001F;
    localparam logic [WORD_W-1:0] W_REBOOT  = 32'h30A1_000E;
    localparam logic [WORD_W-1:0] W_NOOP    = 32'h2000_2000;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } seq_state_e;

endpackage

// File: rtl/cfg_trig_edge.sv
module cfg_trig_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic rise_o
);
    typedef struct packed {
        logic lvl;
    } edge_t;

    edge_t q, d;

    always_comb begin
        d     = q;
        d.lvl = trig_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rise_o = trig_i & ~q.lvl;

    // R6
    held_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_i && $past(trig_i)) |-> !rise_o);

endmodule

// File: rtl/cfg_word_gen.sv
module cfg_word_gen
    import cfg_restart_pkg::*;
#(
    parameter logic [23:0] PRIMARY_ADDR = 24'h40_0000,
    parameter logic [23:0] GOLDEN_ADDR  = 24'h01_0000,
    parameter logic [7:0]  READ_OP      = 8'h03,
    parameter int          IDX_W        = 4
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [WORD_W-1:0] W_PRI_LO = {H_PRI_LO, PRIMARY_ADDR[15:0]};
    localparam logic [WORD_W-1:0] W_PRI_HI = {H_PRI_HI, READ_OP, PRIMARY_ADDR[23:16]};
    localparam logic [WORD_W-1:0] W_GLD_LO = {H_GLD_LO, GOLDEN_ADDR[15:0]};
    localparam logic [WORD_W-1:0] W_GLD_HI = {H_GLD_HI, READ_OP, GOLDEN_ADDR[23:16]};

    always_comb begin
        case (int'(idx_i))
            0:       word_o = W_DUMMY;
            1:       word_o = W_SYNC;
            2:       word_o = W_TIMER;
            3:       word_o = W_PRI_LO;
            4:       word_o = W_PRI_HI;
            5:       word_o = W_GLD_LO;
            6:       word_o = W_GLD_HI;
            7:       word_o = W_USER;
            8:       word_o = W_CMD_NUL;
            9:       word_o = W_CTL;
            10:      word_o = W_HC_OPT;
            11:      word_o = W_REBOOT;
            default: word_o = W_NOOP;
        endcase
    end

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_restart_pkg::*;
#(
    parameter int TOTAL_HALVES = 28,
    parameter int CNT_W        = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic             active_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL_HALVES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st  = ST_SEND;
                    d.cnt = '0;
                end
            end
            ST_SEND: begin
                if (q.cnt == LAST) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: d = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign active_o = (q.st == ST_SEND);
    assign cnt_o    = q.cnt;

    // R4
    step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_SEND && q.cnt != LAST) |=>
            (q.st == ST_SEND && q.cnt == $past(q.cnt) + CNT_W'(1)));

    // R4
    end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_SEND && q.cnt == LAST) |=> (q.st == ST_IDLE));

    // R6
    start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IDLE && start_i) |=> (q.st == ST_SEND && q.cnt == '0));

endmodule

// File: rtl/cfg_restart_seq.sv
module cfg_restart_seq
    import cfg_restart_pkg::*;
#(
    parameter logic [23:0] PRIMARY_ADDR = 24'h40_0000,
    parameter logic [23:0] GOLDEN_ADDR  = 24'h01_0000,
    parameter logic [7:0]  READ_OP      = 8'h03,
    parameter int          PAD_WORDS    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trig_i,
    output logic              busy_o,
    output logic              cap_sel_no,
    output logic              cap_wr_no,
    output logic [HALF_W-1:0] cap_data_o
);
    localparam int NUM_WORDS    = HDR_WORDS + PAD_WORDS;
    localparam int TOTAL_HALVES = 2 * NUM_WORDS;
    localparam int CNT_W        = $clog2(TOTAL_HALVES);
    localparam int IDX_W        = CNT_W - 1;

    logic              start;
    logic              active;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] word;

    cfg_trig_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .trig_i (trig_i),
        .rise_o (start)
    );

    cfg_seq_fsm #(
        .TOTAL_HALVES (TOTAL_HALVES),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start),
        .active_o (active),
        .cnt_o    (cnt)
    );

    cfg_word_gen #(
        .PRIMARY_ADDR (PRIMARY_ADDR),
        .GOLDEN_ADDR  (GOLDEN_ADDR),
        .READ_OP      (READ_OP),
        .IDX_W        (IDX_W)
    ) u_words (
        .idx_i  (cnt[CNT_W-1:1]),
        .word_o (word)
    );

    always_comb begin
        if (!active)     cap_data_o = '1;
        else if (cnt[0]) cap_data_o = word[HALF_W-1:0];
        else             cap_data_o = word[WORD_W-1:HALF_W];
    end

    assign busy_o     = active;
    assign cap_sel_no = ~active;
    assign cap_wr_no  = ~active;

    // R1
    first_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cap_sel_no) |-> (cap_data_o == 16'hFFFF));

    // R1
    second_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cap_sel_no) |=> (cap_data_o == 16'hFFFF && !cap_sel_no));

endmodule

// File: tb/sim_cfg_restart_seq.sv
`timescale 1ns/1ps
module sim_cfg_restart_seq;

    localparam logic [23:0] P1   = 24'h5A_1234;
    localparam logic [23:0] G1   = 24'h0B_CDEF;
    localparam logic [7:0]  OP1  = 8'h6B;
    localparam int          PAD1 = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig0 = 1'b0, trig1 = 1'b0;
    logic busy0, sel0, wr0, busy1, sel1, wr1;
    logic [15:0] dat0, dat1;
    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cfg_restart_seq u0 (
        .clk_i (clk), .rst_ni (rst_n), .trig_i (trig0),
        .busy_o (busy0), .cap_sel_no (sel0), .cap_wr_no (wr0), .cap_data_o (dat0)
    );

    cfg_restart_seq #(
        .PRIMARY_ADDR (P1), .GOLDEN_ADDR (G1), .READ_OP (OP1), .PAD_WORDS (PAD1)
    ) u1 (
        .clk_i (clk), .rst_ni (rst_n), .trig_i (trig1),
        .busy_o (busy1), .cap_sel_no (sel1), .cap_wr_no (wr1), .cap_data_o (dat1)
    );

    function automatic logic [15:0] exp_half(logic [23:0] p, logic [23:0] g,
                                             logic [7:0] op, int k);
        logic [31:0] w;
        case (k / 2)
            0:  w = 32'hFFFFFFFF;
            1:  w = 32'hAA995566;
            2:  w = 32'h31E1FFFF;
            3:  w = {16'h3261, p[15:0]};
            4:  w = {16'h3281, op, p[23:16]};
            5:  w = {16'h32A1, g[15:0]};
            6:  w = {16'h32C1, op, g[23:16]};
            7:  w = 32'h32E10000;
            8:  w = 32'h30A10000;
            9:  w = 32'h33012100;
            10: w = 32'h3201001F;
            11: w = 32'h30A1000E;
            default: w = 32'h20002000;
        endcase
        return (k % 2 == 1) ? w[15:0] : w[31:16];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_trig(input int which, input logic v);
        if (which == 0) trig0 = v; else trig1 = v;
    endtask

    task automatic idle_chk(input int which, input string req);
        if (which == 0) begin
            chk(req, {13'd0, sel0, wr0, busy0}, 16'h0006);
            chk(req, dat0, 16'hFFFF);
        end else begin
            chk(req, {13'd0, sel1, wr1, busy1}, 16'h0006);
            chk(req, dat1, 16'hFFFF);
        end
    endtask

    // Caller raises the trigger at a negedge, then calls this task.
    task automatic run_burst(input int which, input bit hold, input int poke_a, input int poke_b);
        int total = (which == 0) ? 28 : 2 * (12 + PAD1);
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            if (which == 0) begin
                chk("R4 select/write low", {14'd0, sel0, wr0}, 16'h0000);
                chk("R8 busy high in burst", {15'd0, busy0}, 16'h0001);
                chk(k < 4 ? "R1 dummy/sync" : (k < 22 ? "R2 register words" : "R3 reboot/pad"),
                    dat0, exp_half(24'h400000, 24'h010000, 8'h03, k));
            end else begin
                chk("R4 select/write low", {14'd0, sel1, wr1}, 16'h0000);
                chk(k < 22 ? "R2 param register words" : "R3 param reboot/pad",
                    dat1, exp_half(P1, G1, OP1, k));
            end
            if (!hold) set_trig(which, (k == poke_a || k == poke_b));
        end
        @(negedge clk);
        idle_chk(which, "R4 end of burst");
    endtask

    task automatic t_reset();
        @(negedge clk);
        idle_chk(0, "R5 in reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        idle_chk(0, "R5 after reset");
        idle_chk(1, "R5 after reset");
    endtask

    task automatic t_basic();
        trig0 = 1'b1;
        run_burst(0, 0, -1, -1);
        repeat (5) @(negedge clk);
        idle_chk(0, "R5 idle after burst");
    endtask

    task automatic t_held();
        trig0 = 1'b1;
        run_burst(0, 1, -1, -1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R6 held trigger single burst", {15'd0, sel0}, 16'h0001);
        end
        trig0 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_ignore();
        trig0 = 1'b1;
        run_burst(0, 0, 5, 20);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R7 edges in burst ignored", {15'd0, sel0}, 16'h0001);
        end
    endtask

    task automatic t_b2b();
        trig0 = 1'b1;
        run_burst(0, 0, -1, -1);
        trig0 = 1'b1;   // edge in the first idle cycle
        @(negedge clk);
        trig0 = 1'b0;
        chk("R9 back-to-back start", {15'd0, sel0}, 16'h0000);
        chk("R9 back-to-back first half", dat0, 16'hFFFF);
        for (int i = 1; i < 28; i++) @(negedge clk);
        @(negedge clk);
        idle_chk(0, "R9 second burst end");
    endtask

    task automatic t_params();
        trig1 = 1'b1;
        run_burst(1, 0, -1, -1);
        repeat (3) @(negedge clk);
        idle_chk(1, "R3 param idle after pad");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_held();
        t_ignore();
        t_b2b();
        t_params();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule